// File: doc/BRIEF.md
# Change-Triggered Logic Capture Unit

This block records the levels of a group of digital probe lines into on-chip memory. It does not take a sample every clock. It writes a new entry only when the synchronised probe vector differs from the entry it wrote last. Quiet stretches therefore cost no memory. No timing information is kept, so each stored word holds only the probe levels.

A host microcontroller reaches the block over a byte-wide asynchronous bus with chip select, read strobe, write strobe and a two-bit address. The block synchronises the strobes to its own clock. The host arms and disarms capture through a control register and reads how many entries have been stored. It then drains the stored words through a data port that needs no address. Each word is read as two bytes, and every read moves on by itself.

Top module: `chgcap_top`

## Requirements
- R1: After reset the control/status register (address 0) reads 0x00 and both counter bytes read 0x00. Probe changes while the block is not armed store nothing.
- R2: Writing 1 to bit 0 of address 0 while that bit is 0 arms capture. The first synchronised sample after arming is stored whatever its value, so the counter becomes 1.
- R3: While armed, an entry is stored only when the probe vector differs from the last stored vector. A vector that is held steady adds no entries, and the counter only increases, one step at a time.
- R4: A change in any single probe line, the highest channel included, stores an entry.
- R5: Address 1 returns counter bits 7:0 and address 2 returns counter bits 12:8 in bits 4:0, with the upper bits zero.
- R6: Address 3 returns entries in the order they were stored. The first read of an entry gives probe bits 7:0. The second read gives probe bits 13:8 in data bits 5:0, with bits 7:6 zero, and then advances to the next entry.
- R7: When every stored entry has been read, address 3 returns 0x00, the read position does not advance, and the counter is unchanged.
- R8: When the counter reaches 4096, status bit 1 (done) reads 1 and capture stops. Later probe changes leave the counter at 4096 and the stored data untouched.
- R9: Writing 0 to bit 0 of address 0 disarms capture and clears the counter, the done bit and both read and write positions. Re-arming from the disarmed state clears them too.
- R10: Writes to addresses 1, 2 and 3 have no effect. A write to address 0 only changes bit 0: writing 1 to bit 1 does not set done, and writing 1 while already armed does not restart capture.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Capture and register clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| probe_in | input | 14 | Asynchronous probe lines to be captured |
| bus_cs_n | input | 1 | Host chip select, active low |
| bus_rd_n | input | 1 | Host read strobe, active low |
| bus_wr_n | input | 1 | Host write strobe, active low |
| bus_addr | input | 2 | Register select: 0 control/status, 1 counter low, 2 counter high, 3 data port |
| bus_din | input | 8 | Host write data |
| bus_dout | output | 8 | Host read data for the selected register |

## Verification
On every cycle, the assertions check the following. The counter never passes the capture depth. It moves only by one step up, or to zero. It stays frozen once the store is full. The read position never runs ahead of the counter. A clear empties the store on the next cycle. Each host write becomes exactly one internal strobe. Only the bench scenarios can show that steady vectors add nothing while single-bit changes on the edge channels do add entries. They also show that data comes back low byte first and in store order, that an empty port reads zero, and that writes to read-only addresses leave the observable state alone.

// File: rtl/chgcap_pkg.sv
package chgcap_pkg;
  localparam int BUS_W = 8;

  typedef enum logic [1:0] {
    REG_CTRL   = 2'd0,
    REG_CNT_LO = 2'd1,
    REG_CNT_HI = 2'd2,
    REG_DATA   = 2'd3
  } reg_sel_e;
endpackage

// File: rtl/chgcap_sync.sv
module chgcap_sync #(
  parameter int         W       = 1,
  parameter logic       RST_VAL = 1'b0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] meta_q, sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= {W{RST_VAL}};
      sync_q <= {W{RST_VAL}};
    end else begin
      meta_q <= d;
      sync_q <= meta_q;
    end
  end

  assign q = sync_q;
endmodule

// File: rtl/chgcap_host_if.sv
module chgcap_host_if
  import chgcap_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     cs_n,
  input  logic     rd_n,
  input  logic     wr_n,
  input  logic [1:0] addr,
  output logic     wr_stb,
  output logic     rd_done,
  output reg_sel_e rd_sel
);
  logic [2:0] strb_s;
  logic       wr_act, rd_act;
  logic       wr_act_q, rd_act_q;
  reg_sel_e   rd_sel_q, rd_sel_d;

  chgcap_sync #(.W(3), .RST_VAL(1'b1)) u_strb_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     ({cs_n, rd_n, wr_n}),
    .q     (strb_s)
  );

  assign wr_act  = !strb_s[2] && !strb_s[0];
  assign rd_act  = !strb_s[2] && !strb_s[1];
  assign wr_stb  = wr_act && !wr_act_q;
  assign rd_done = !rd_act && rd_act_q;

  always_comb begin
    rd_sel_d = rd_sel_q;
    if (rd_act && !rd_act_q) rd_sel_d = reg_sel_e'(addr);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_act_q <= 1'b0;
      rd_act_q <= 1'b0;
      rd_sel_q <= REG_CTRL;
    end else begin
      wr_act_q <= wr_act;
      rd_act_q <= rd_act;
      rd_sel_q <= rd_sel_d;
    end
  end

  assign rd_sel = rd_sel_q;

  assert_wr_single_R10: assert property (@(posedge clk) disable iff (!rst_n)
    wr_stb |=> !wr_stb);
  assert_rd_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
    rd_done |=> !rd_done);
endmodule

// File: rtl/chgcap_store.sv
module chgcap_store #(
  parameter int NUM_CH = 14,
  parameter int ADDR_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NUM_CH-1:0] smp,
  input  logic              cap_en,
  input  logic              arm_clr,
  input  logic              rd_adv,
  output logic [ADDR_W:0]   count,
  output logic              done,
  output logic              empty,
  output logic [NUM_CH-1:0] rd_word
);
  localparam int DEPTH = 1 << ADDR_W;
  localparam int CNT_W = ADDR_W + 1;

  logic [NUM_CH-1:0] mem [DEPTH];
  logic [NUM_CH-1:0] last_q, last_d, rd_q;
  logic [CNT_W-1:0]  cnt_q, cnt_d, rptr_q, rptr_d;
  logic              first_q, first_d, done_q, done_d;
  logic              we;

  assign we = cap_en && !done_q && !arm_clr && (first_q || (smp != last_q));

  always_comb begin
    last_d  = last_q;
    cnt_d   = cnt_q;
    rptr_d  = rptr_q;
    first_d = first_q;
    done_d  = done_q;
    if (arm_clr) begin
      cnt_d   = '0;
      rptr_d  = '0;
      first_d = 1'b1;
      done_d  = 1'b0;
    end else begin
      if (we) begin
        last_d  = smp;
        first_d = 1'b0;
        cnt_d   = cnt_q + 1'b1;
        if (cnt_q == CNT_W'(DEPTH - 1)) done_d = 1'b1;
      end
      if (rd_adv && (rptr_q != cnt_q)) rptr_d = rptr_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      last_q  <= '0;
      cnt_q   <= '0;
      rptr_q  <= '0;
      first_q <= 1'b1;
      done_q  <= 1'b0;
    end else begin
      last_q  <= last_d;
      cnt_q   <= cnt_d;
      rptr_q  <= rptr_d;
      first_q <= first_d;
      done_q  <= done_d;
    end
  end

  always_ff @(posedge clk) begin
    if (we) mem[cnt_q[ADDR_W-1:0]] <= smp;
    rd_q <= mem[rptr_q[ADDR_W-1:0]];
  end

  assign count   = cnt_q;
  assign done    = done_q;
  assign empty   = (rptr_q == cnt_q);
  assign rd_word = rd_q;

  assert_count_max_R8: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CNT_W'(DEPTH));
  assert_full_freeze_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (done_q && $past(done_q) && !$past(arm_clr)) |-> $stable(cnt_q));
  assert_count_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(cnt_q) |-> ((cnt_q == $past(cnt_q) + 1'b1) || (cnt_q == '0)));
  assert_rdptr_bound_R7: assert property (@(posedge clk) disable iff (!rst_n)
    rptr_q <= cnt_q);
  assert_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
    arm_clr |=> (cnt_q == '0 && !done_q && rptr_q == '0));
endmodule

// File: rtl/chgcap_top.sv
module chgcap_top
  import chgcap_pkg::*;
#(
  parameter int NUM_CH = 14,
  parameter int ADDR_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NUM_CH-1:0] probe_in,
  input  logic              bus_cs_n,
  input  logic              bus_rd_n,
  input  logic              bus_wr_n,
  input  logic [1:0]        bus_addr,
  input  logic [BUS_W-1:0]  bus_din,
  output logic [BUS_W-1:0]  bus_dout
);
  localparam int CNT_W  = ADDR_W + 1;
  localparam int WORD_W = 2 * BUS_W;

  logic [1:0]        rst_ff;
  logic              rst_s_n;
  logic [NUM_CH-1:0] probe_s, rd_word;
  logic [CNT_W-1:0]  count;
  logic              done, empty;
  logic              wr_stb, rd_done;
  reg_sel_e          rd_sel;
  logic              start_q, start_d, hi_q, hi_d;
  logic              ctrl_wr, arm_clr, data_rd, rd_adv;
  logic [WORD_W-1:0] word_ext;
  logic [CNT_W-1:0]  cnt_hi;
  logic              unused_din;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_ff <= 2'b00;
    else        rst_ff <= {rst_ff[0], 1'b1};
  end
  assign rst_s_n = rst_ff[1];

  chgcap_sync #(.W(NUM_CH), .RST_VAL(1'b0)) u_probe_sync (
    .clk   (clk),
    .rst_n (rst_s_n),
    .d     (probe_in),
    .q     (probe_s)
  );

  chgcap_host_if u_host (
    .clk     (clk),
    .rst_n   (rst_s_n),
    .cs_n    (bus_cs_n),
    .rd_n    (bus_rd_n),
    .wr_n    (bus_wr_n),
    .addr    (bus_addr),
    .wr_stb  (wr_stb),
    .rd_done (rd_done),
    .rd_sel  (rd_sel)
  );

  assign ctrl_wr = wr_stb && (reg_sel_e'(bus_addr) == REG_CTRL);
  assign arm_clr = ctrl_wr && (!bus_din[0] || !start_q);
  assign data_rd = rd_done && (rd_sel == REG_DATA) && !empty;
  assign rd_adv  = data_rd && hi_q;
  assign unused_din = ^bus_din[BUS_W-1:1];

  always_comb begin
    start_d = start_q;
    hi_d    = hi_q;
    if (ctrl_wr) start_d = bus_din[0];
    if (arm_clr)      hi_d = 1'b0;
    else if (data_rd) hi_d = !hi_q;
  end

  always_ff @(posedge clk or negedge rst_s_n) begin
    if (!rst_s_n) begin
      start_q <= 1'b0;
      hi_q    <= 1'b0;
    end else begin
      start_q <= start_d;
      hi_q    <= hi_d;
    end
  end

  chgcap_store #(.NUM_CH(NUM_CH), .ADDR_W(ADDR_W)) u_store (
    .clk     (clk),
    .rst_n   (rst_s_n),
    .smp     (probe_s),
    .cap_en  (start_q),
    .arm_clr (arm_clr),
    .rd_adv  (rd_adv),
    .count   (count),
    .done    (done),
    .empty   (empty),
    .rd_word (rd_word)
  );

  assign word_ext = WORD_W'(rd_word);
  assign cnt_hi   = count >> BUS_W;

  always_comb begin
    unique case (reg_sel_e'(bus_addr))
      REG_CTRL:   bus_dout = {{(BUS_W-2){1'b0}}, done, start_q};
      REG_CNT_LO: bus_dout = count[BUS_W-1:0];
      REG_CNT_HI: bus_dout = BUS_W'(cnt_hi);
      REG_DATA:   bus_dout = empty ? '0 :
                             (hi_q ? word_ext[WORD_W-1:BUS_W] : word_ext[BUS_W-1:0]);
      default:    bus_dout = '0;
    endcase
  end

  assert_ro_start_R10: assert property (@(posedge clk) disable iff (!rst_s_n)
    (wr_stb && reg_sel_e'(bus_addr) != REG_CTRL) |=> $stable(start_q));
  assert_hi_reset_R9: assert property (@(posedge clk) disable iff (!rst_s_n)
    arm_clr |=> !hi_q);
endmodule

// File: tb/chgcap_top_tb.sv
module chgcap_top_tb;
  localparam int NCH = 14;

  logic           clk = 1'b0;
  logic           rst_n;
  logic [NCH-1:0] probe;
  logic           cs_n, rd_n, wr_n;
  logic [1:0]     addr;
  logic [7:0]     din, dout;

  int checks = 0;
  int fails  = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  chgcap_top u_dut (
    .clk      (clk),
    .rst_n    (rst_n),
    .probe_in (probe),
    .bus_cs_n (cs_n),
    .bus_rd_n (rd_n),
    .bus_wr_n (wr_n),
    .bus_addr (addr),
    .bus_din  (din),
    .bus_dout (dout)
  );

  // row: {probe vector[26:13], expected counter[12:0]}
  localparam logic [26:0] VEC [10] = '{
    {14'h0000, 13'd1}, {14'h0001, 13'd2}, {14'h0001, 13'd2}, {14'h2000, 13'd3},
    {14'h3FFF, 13'd4}, {14'h3FFF, 13'd4}, {14'h0000, 13'd5}, {14'h1555, 13'd6},
    {14'h2AAA, 13'd7}, {14'h2AAA, 13'd7}
  };

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic bus_rd(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk);
    addr = a; cs_n = 1'b0; rd_n = 1'b0;
    repeat (5) @(negedge clk);
    d = dout;
    rd_n = 1'b1; cs_n = 1'b1;
    repeat (5) @(negedge clk);
  endtask

  task automatic bus_wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    addr = a; din = d; cs_n = 1'b0; wr_n = 1'b0;
    repeat (5) @(negedge clk);
    wr_n = 1'b1; cs_n = 1'b1;
    repeat (5) @(negedge clk);
  endtask

  task automatic rd_count(output int c);
    logic [7:0] lo, hi;
    bus_rd(2'd1, lo);
    bus_rd(2'd2, hi);
    c = {hi, lo};
  endtask

  initial begin
    #(10 * 150000);
    if (!finished) begin
      checks++; fails++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    logic [7:0]     b, lo, hi;
    int             c;
    logic [NCH-1:0] exp_mem [16];
    logic [NCH-1:0] last;
    int             n_exp;

    rst_n = 1'b0; probe = '0; cs_n = 1'b1; rd_n = 1'b1; wr_n = 1'b1;
    addr = '0; din = '0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1: reset state, disarmed capture ignores probes
    bus_rd(2'd0, b); check("R1 status", b, 8'h00);
    probe = 14'h0123; repeat (6) @(negedge clk);
    rd_count(c); check("R1 count", c, 0);
    probe = '0; repeat (6) @(negedge clk);

    // R2: arm stores first sample
    bus_wr(2'd0, 8'h01);
    bus_rd(2'd0, b); check("R2 armed status", b, 8'h01);

    // R3 R4 R5: vector walk
    exp_mem[0] = '0; last = '0; n_exp = 1;
    for (int i = 0; i < 10; i++) begin
      probe = VEC[i][26:13];
      if (probe != last) begin
        exp_mem[n_exp] = probe; n_exp++; last = probe;
      end
      repeat (4) @(negedge clk);
      rd_count(c);
      check("R3/R4/R5 count after vector", c, int'(VEC[i][12:0]));
    end

    // R10: writes to read-only places do nothing
    bus_wr(2'd1, 8'hFF);
    bus_wr(2'd2, 8'hFF);
    bus_wr(2'd3, 8'hFF);
    bus_wr(2'd0, 8'h03);
    rd_count(c); check("R10 count unchanged", c, 7);
    bus_rd(2'd0, b); check("R10 status unchanged", b, 8'h01);

    // R6: readout order and byte layout
    for (int k = 0; k < n_exp; k++) begin
      bus_rd(2'd3, lo);
      bus_rd(2'd3, hi);
      check("R6 low byte", lo, int'(exp_mem[k][7:0]));
      check("R6 high byte", hi, int'({2'b00, exp_mem[k][13:8]}));
    end

    // R7: empty port
    bus_rd(2'd3, b); check("R7 empty read", b, 8'h00);
    bus_rd(2'd3, b); check("R7 empty read again", b, 8'h00);
    rd_count(c); check("R7 count unchanged", c, 7);

    // R9: disarm clears
    bus_wr(2'd0, 8'h00);
    rd_count(c); check("R9 count cleared", c, 0);
    bus_rd(2'd0, b); check("R9 status cleared", b, 8'h00);

    // R8: fill to capacity
    probe = '0;
    bus_wr(2'd0, 8'h01);
    for (int t = 0; t < 4200; t++) begin
      @(negedge clk); probe[0] = ~probe[0];
    end
    repeat (4) @(negedge clk);
    bus_rd(2'd0, b); check("R8 done status", b, 8'h03);
    rd_count(c); check("R8 full count", c, 4096);
    probe = 14'h3FFF; repeat (6) @(negedge clk);
    probe = 14'h1234; repeat (6) @(negedge clk);
    rd_count(c); check("R8 frozen count", c, 4096);
    for (int k = 0; k < 3; k++) begin
      bus_rd(2'd3, lo);
      bus_rd(2'd3, hi);
      check("R8 stored low byte", lo, (k % 2 == 1) ? 1 : 0);
      check("R8 stored high byte", hi, 0);
    end

    // R9: disarm clears done
    bus_wr(2'd0, 8'h00);
    bus_rd(2'd0, b); check("R9 done cleared", b, 8'h00);
    rd_count(c); check("R9 count after full", c, 0);

    finished = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule